// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads a configuration image into a target FPGA over a passive serial link. A single start pulse with a total byte count begins a configuration. The image bytes then arrive on a valid/ready byte stream. The block drives the target's active-low configuration-reset line, the serial clock, the serial data line and an active-low chip-enable. It watches two target outputs: the active-low status line and the configuration-complete line. Each of those passes through a two-flop synchroniser before any decision uses it.

Each attempt runs in a fixed order. It opens with a settling wait and then pulses the reset line low with the serial clock held low. The status line must follow the reset line low. After that the block releases the reset line and waits again. It then shifts the image out least-significant bit first and checks the status line in every clock-high phase. After the last data bit it sends a fixed run of extra clocks, drives the data line low and samples the completion line. A status error during the transfer, or a missing completion, starts a new attempt. Before a new attempt begins, the block pulses a rewind output so that the source replays the image from its first byte. The number of attempts is bounded. All waits are counted in system clocks from a clock-frequency parameter.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, the chip-enable and reset-line outputs are high and the serial clock, serial data, busy, done, fail, rewind and ready outputs are low. Once an accepted start drives the chip-enable low, it stays low.
- R2: After a start, at least PRE_US worth of clocks pass before the reset line falls. The reset line then stays low for exactly LOW_US worth of clocks, and the serial clock stays low the whole time the reset line is low.
- R3: If the synchronised status line is still high at the end of the reset-low window, the block ends with fail and does not retry (exactly one reset pulse).
- R4: After the reset line is released, at least POST_US worth of clocks pass before the first rising serial clock edge.
- R5: Every data bit is valid on the data line when its serial clock rises. Bytes go out in stream order, and within each byte bit 0 goes first and bit 7 last.
- R6: If the status line reads low during a serial clock high phase, the attempt is abandoned. The rewind output pulses for one cycle and a new attempt replays the image from the first byte.
- R7: After the last data bit (or straight after the release wait when the count is zero), exactly TRAIL_CLKS (default 1200) extra serial clock pulses follow. The data line is then driven low and stays low while done is held.
- R8: If the synchronised completion line is high after the trailing clocks, done goes high. If it is low, a new attempt starts (with a rewind pulse).
- R9: At most MAX_TRIES (default 5) reset pulses occur per start. When the last allowed attempt fails, fail goes high with no further rewind, so a run shows attempts−1 rewinds.
- R10: A byte count above MAX_BYTES (default 524288) ends with fail within two cycles. It produces no reset pulse and no chip-enable change. A count of zero is legal.
- R11: Busy is high from the cycle after an accepted start until done or fail. Done and fail are never high together, they hold until the next start, and ready is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration (accepted when not busy) |
| byte_count | input | CNT_W | Total image length in bytes, sampled with start |
| in_data | input | 8 | Image byte from the source |
| in_valid | input | 1 | Source has a byte on in_data |
| in_ready | output | 1 | Block takes in_data this cycle when in_valid is high |
| rewind | output | 1 | One-cycle request to restart the byte stream at byte 0 |
| cfg_ce_n | output | 1 | Active-low chip-enable to the target |
| cfg_nconfig | output | 1 | Active-low configuration reset to the target |
| cfg_dclk | output | 1 | Serial configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| cfg_nstatus | input | 1 | Active-low status from the target (asynchronous) |
| cfg_conf_done | input | 1 | Configuration-complete flag from the target (asynchronous) |
| busy | output | 1 | A configuration is in progress |
| done | output | 1 | Last configuration finished successfully |
| fail | output | 1 | Last configuration was rejected or ran out of attempts |

## Verification
A behavioural target model rebuilds every byte from the data line at each rising serial clock. It counts reset pulses, rewinds and trailing clocks, so lost or swapped bit order and wrong pulse counts are seen at the pins. The main function is run with several image lengths: a clean image, an empty image, and images with a status error injected at a mid-byte bit or at the very first bit. Other runs withhold the completion flag for some or all attempts, or keep the status line stuck high. Together these separate the restart-with-rewind path, the no-retry abort path and the attempt limit. An oversized count shows that rejection happens before any pin moves.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_LOW,
        ST_REL,
        ST_FETCH,
        ST_BHI,
        ST_BLO,
        ST_THI,
        ST_TLO,
        ST_CHECK,
        ST_RETRY,
        ST_DONE,
        ST_FAIL
    } st_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // microseconds to clock cycles, rounded up, never below one cycle
    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        int unsigned r;
        r = ((hz / 1000) * us + 999) / 1000;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] ff_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) ff_q[i] <= '0;
        end else begin
            ff_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
        end
    end

    assign d_out = ff_q[STAGES-1];

endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic         next_bit,
    output logic         last
);

    localparam int unsigned IDX_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_val;
            idx_q <= '0;
        end else if (advance) begin
            sr_q  <= sr_q >> 1;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // sr_q[0] is the bit on the line now; sr_q[1] goes out next
    assign next_bit = sr_q[1];
    assign last     = (idx_q == IDX_W'(W - 1));

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned PRE_US      = 100,
    parameter int unsigned LOW_US      = 10,
    parameter int unsigned POST_US     = 100,
    parameter int unsigned DCLK_HALF   = 4,
    parameter int unsigned TRAIL_CLKS  = 1200,
    parameter int unsigned MAX_TRIES   = 5,
    parameter int unsigned MAX_BYTES   = 524288,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             rewind,
    output logic             cfg_ce_n,
    output logic             cfg_nconfig,
    output logic             cfg_dclk,
    output logic             cfg_data,
    input  logic             cfg_nstatus,
    input  logic             cfg_conf_done,
    output logic             busy,
    output logic             done,
    output logic             fail
);

    localparam int unsigned PRE_CYC  = us_to_cycles(CLK_HZ, PRE_US);
    localparam int unsigned LOW_CYC  = max2(us_to_cycles(CLK_HZ, LOW_US), SYNC_STAGES + 1);
    localparam int unsigned POST_CYC = us_to_cycles(CLK_HZ, POST_US);
    // high phase must outlast the synchroniser so an error raised at the edge is seen
    localparam int unsigned HI_CYC   = max2(DCLK_HALF, SYNC_STAGES + 1);
    localparam int unsigned LO_CYC   = max2(DCLK_HALF, 1);
    localparam int unsigned TMAX     = max2(max2(PRE_CYC, POST_CYC), max2(LOW_CYC, HI_CYC));
    localparam int unsigned TMR_W    = $clog2(TMAX + 1);
    localparam int unsigned TRL_W    = $clog2(TRAIL_CLKS + 1);
    localparam int unsigned TRY_W    = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        st_e              st;
        logic [TMR_W-1:0] tmr;
        logic [TRY_W-1:0] tries;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] left;
        logic [TRL_W-1:0] trl;
        logic             nconfig;
        logic             dclk;
        logic             data;
        logic             ce_n;
        logic             rewind;
        logic             done;
        logic             fail;
    } regs_t;

    regs_t q, n;

    logic [1:0] sync_out;
    logic       ns_s;
    logic       cd_s;
    logic       sh_load;
    logic       sh_adv;
    logic       sh_next;
    logic       sh_last;

    ps_cfg_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cfg_nstatus, cfg_conf_done}),
        .d_out (sync_out)
    );

    assign ns_s = sync_out[1];
    assign cd_s = sync_out[0];

    ps_cfg_shift #(
        .W (8)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (in_data),
        .advance  (sh_adv),
        .next_bit (sh_next),
        .last     (sh_last)
    );

    always_comb begin
        n       = q;
        n.rewind = 1'b0;
        sh_load = 1'b0;
        sh_adv  = 1'b0;

        unique case (q.st)
            ST_PRE: begin
                if (q.tmr == '0) begin
                    n.nconfig = 1'b0;
                    n.dclk    = 1'b0;
                    n.tmr     = TMR_W'(LOW_CYC - 1);
                    n.st      = ST_LOW;
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_LOW: begin
                if (q.tmr == '0) begin
                    n.nconfig = 1'b1;
                    if (ns_s) begin
                        n.fail = 1'b1;
                        n.st   = ST_FAIL;
                    end else begin
                        n.tmr = TMR_W'(POST_CYC - 1);
                        n.st  = ST_REL;
                    end
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_REL: begin
                if (q.tmr == '0) begin
                    if (q.left != '0) begin
                        n.st = ST_FETCH;
                    end else if (TRAIL_CLKS == 0) begin
                        n.data = 1'b0;
                        n.st   = ST_CHECK;
                    end else begin
                        n.dclk = 1'b1;
                        n.trl  = TRL_W'(TRAIL_CLKS - 1);
                        n.tmr  = TMR_W'(HI_CYC - 1);
                        n.st   = ST_THI;
                    end
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_FETCH: begin
                if (in_valid) begin
                    sh_load = 1'b1;
                    n.data  = in_data[0];
                    n.dclk  = 1'b1;
                    n.tmr   = TMR_W'(HI_CYC - 1);
                    n.left  = q.left - CNT_W'(1);
                    n.st    = ST_BHI;
                end
            end

            ST_BHI: begin
                if (q.tmr == '0) begin
                    n.dclk = 1'b0;
                    if (!ns_s) begin
                        n.st = ST_RETRY;
                    end else begin
                        n.tmr = TMR_W'(LO_CYC - 1);
                        n.st  = ST_BLO;
                    end
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_BLO: begin
                if (q.tmr == '0) begin
                    if (!sh_last) begin
                        sh_adv = 1'b1;
                        n.data = sh_next;
                        n.dclk = 1'b1;
                        n.tmr  = TMR_W'(HI_CYC - 1);
                        n.st   = ST_BHI;
                    end else if (q.left != '0) begin
                        n.st = ST_FETCH;
                    end else if (TRAIL_CLKS == 0) begin
                        n.data = 1'b0;
                        n.st   = ST_CHECK;
                    end else begin
                        n.dclk = 1'b1;
                        n.trl  = TRL_W'(TRAIL_CLKS - 1);
                        n.tmr  = TMR_W'(HI_CYC - 1);
                        n.st   = ST_THI;
                    end
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_THI: begin
                if (q.tmr == '0) begin
                    n.dclk = 1'b0;
                    n.tmr  = TMR_W'(LO_CYC - 1);
                    n.st   = ST_TLO;
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_TLO: begin
                if (q.tmr == '0) begin
                    if (q.trl == '0) begin
                        n.data = 1'b0;
                        n.st   = ST_CHECK;
                    end else begin
                        n.trl  = q.trl - TRL_W'(1);
                        n.dclk = 1'b1;
                        n.tmr  = TMR_W'(HI_CYC - 1);
                        n.st   = ST_THI;
                    end
                end else begin
                    n.tmr = q.tmr - TMR_W'(1);
                end
            end

            ST_CHECK: begin
                if (cd_s) begin
                    n.done = 1'b1;
                    n.st   = ST_DONE;
                end else begin
                    n.st = ST_RETRY;
                end
            end

            ST_RETRY: begin
                n.dclk = 1'b0;
                n.data = 1'b0;
                if (q.tries == TRY_W'(MAX_TRIES)) begin
                    n.fail = 1'b1;
                    n.st   = ST_FAIL;
                end else begin
                    n.tries  = q.tries + TRY_W'(1);
                    n.rewind = 1'b1;
                    n.left   = q.total;
                    n.tmr    = TMR_W'(PRE_CYC - 1);
                    n.st     = ST_PRE;
                end
            end

            default: begin
                // idle, done and fail all wait for a new start
                if (start) begin
                    n.done = 1'b0;
                    n.fail = 1'b0;
                    if (byte_count > CNT_W'(MAX_BYTES)) begin
                        n.fail = 1'b1;
                        n.st   = ST_FAIL;
                    end else begin
                        n.ce_n  = 1'b0;
                        n.tries = TRY_W'(1);
                        n.total = byte_count;
                        n.left  = byte_count;
                        n.dclk  = 1'b0;
                        n.data  = 1'b0;
                        n.tmr   = TMR_W'(PRE_CYC - 1);
                        n.st    = ST_PRE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.nconfig <= 1'b1;
            q.ce_n    <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign in_ready    = (q.st == ST_FETCH);
    assign busy        = !((q.st == ST_IDLE) || (q.st == ST_DONE) || (q.st == ST_FAIL));
    assign rewind      = q.rewind;
    assign cfg_ce_n    = q.ce_n;
    assign cfg_nconfig = q.nconfig;
    assign cfg_dclk    = q.dclk;
    assign cfg_data    = q.data;
    assign done        = q.done;
    assign fail        = q.fail;

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
    parameter int unsigned MAX_TRIES = 5
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic ce_n,
    input logic nconfig,
    input logic dclk,
    input logic data,
    input logic rewind,
    input logic in_ready
);

    logic [7:0] pulses_q;
    logic       ncfg_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses_q    <= '0;
            ncfg_prev_q <= 1'b1;
        end else begin
            ncfg_prev_q <= nconfig;
            if (start && !busy) begin
                pulses_q <= '0;
            end else if (ncfg_prev_q && !nconfig) begin
                pulses_q <= pulses_q + 8'd1;
            end
        end
    end

    assert_ce_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> !ce_n);

    assert_dclk_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nconfig |-> !dclk);

    assert_rewind_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> !rewind);

    assert_data_low_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !data);

    assert_try_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= 8'(MAX_TRIES));

    assert_status_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_ready_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

endmodule

bind ps_cfg_master ps_cfg_master_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .ce_n     (cfg_ce_n),
    .nconfig  (cfg_nconfig),
    .dclk     (cfg_dclk),
    .data     (cfg_data),
    .rewind   (rewind),
    .in_ready (in_ready)
);

// File: tb/ps_cfg_master_bench.sv
module ps_cfg_master_bench;

    localparam int unsigned MAXB  = 524288;
    localparam int unsigned CW    = $clog2(MAXB + 1);
    localparam int unsigned TRAIL = 1200;

    typedef struct packed {
        logic [19:0] n;
        logic [3:0]  err_att;
        logic [15:0] err_bit;
        logic [3:0]  cd_bad;
        logic        stuck;
        logic        exp_done;
        logic [3:0]  exp_att;
        logic [3:0]  exp_rew;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20'd5, 4'd0, 16'd0,  4'd0, 1'b0, 1'b1, 4'd1, 4'd0},
        '{20'd4, 4'd1, 16'd13, 4'd0, 1'b0, 1'b1, 4'd2, 4'd1},
        '{20'd3, 4'd0, 16'd0,  4'd4, 1'b0, 1'b1, 4'd5, 4'd4},
        '{20'd2, 4'd0, 16'd0,  4'd5, 1'b0, 1'b0, 4'd5, 4'd4},
        '{20'd3, 4'd0, 16'd0,  4'd0, 1'b1, 1'b0, 4'd1, 4'd0},
        '{20'd0, 4'd0, 16'd0,  4'd0, 1'b0, 1'b1, 4'd1, 4'd0},
        '{20'd6, 4'd2, 16'd0,  4'd1, 1'b0, 1'b1, 4'd3, 4'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [7:0]    in_data;
    logic          in_valid;
    logic          in_ready;
    logic          rewind;
    logic          cfg_ce_n, cfg_nconfig, cfg_dclk, cfg_data;
    logic          cfg_nstatus, cfg_conf_done;
    logic          busy, done, fail;

    // vector configuration
    int   cur_n = 0;
    int   err_att = 0;
    int   err_bit = 0;
    int   cd_bad = 0;
    logic stuck = 1'b0;

    // target model state
    int   idx = 0;
    int   att = 0;
    int   bits = 0;
    int   trail = 0;
    int   mism = 0;
    int   rew = 0;
    logic err = 1'b0;
    logic prev_ncfg = 1'b1;
    logic prev_dclk = 1'b0;
    logic pre_run = 1'b0;
    int   pre_cnt = 0, pre_w = 0;
    int   low_cnt = 0, low_w = 0;
    logic gap_run = 1'b0;
    int   gap_cnt = 0, gap_w = 0;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    logic timeout = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 91) ^ (i >> 3));
    endfunction

    logic hit;
    assign hit = cfg_dclk && cfg_nconfig && (att == err_att) && (bits == err_bit) && (bits < 8 * cur_n);
    assign cfg_nstatus   = stuck ? 1'b1 : (cfg_nconfig && !(hit || err));
    assign cfg_conf_done = (att > cd_bad) && (bits >= 8 * cur_n);
    assign in_valid      = (idx < cur_n);
    assign in_data       = pat(idx);

    ps_cfg_master #(
        .CLK_HZ    (1_000_000),
        .DCLK_HALF (2)
    ) u_ps_cfg_master (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .byte_count    (byte_count),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .rewind        (rewind),
        .cfg_ce_n      (cfg_ce_n),
        .cfg_nconfig   (cfg_nconfig),
        .cfg_dclk      (cfg_dclk),
        .cfg_data      (cfg_data),
        .cfg_nstatus   (cfg_nstatus),
        .cfg_conf_done (cfg_conf_done),
        .busy          (busy),
        .done          (done),
        .fail          (fail)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000) timeout <= 1'b1;
    end

    // source and target model, working on pre-edge values
    always @(posedge clk) begin
        if (start) begin
            att <= 0; bits <= 0; err <= 1'b0; trail <= 0; mism <= 0; rew <= 0; idx <= 0;
            pre_run <= 1'b1; pre_cnt <= 0; low_cnt <= 0; gap_run <= 1'b0; gap_cnt <= 0;
            prev_ncfg <= cfg_nconfig; prev_dclk <= cfg_dclk;
        end else begin
            prev_ncfg <= cfg_nconfig;
            prev_dclk <= cfg_dclk;
            if (rewind) begin
                rew <= rew + 1;
                idx <= 0;
            end else if (in_valid && in_ready) begin
                idx <= idx + 1;
            end
            if (pre_run) begin
                if (!cfg_nconfig) begin
                    pre_run <= 1'b0;
                    pre_w   <= pre_cnt;
                end else begin
                    pre_cnt <= pre_cnt + 1;
                end
            end
            if (prev_ncfg && !cfg_nconfig) begin
                att <= att + 1; bits <= 0; err <= 1'b0; trail <= 0; low_cnt <= 1;
            end else if (!cfg_nconfig) begin
                low_cnt <= low_cnt + 1;
            end
            if (!prev_ncfg && cfg_nconfig) begin
                low_w   <= low_cnt;
                gap_run <= 1'b1;
                gap_cnt <= 0;
            end
            if (!prev_dclk && cfg_dclk) begin
                gap_run <= 1'b0;
                if (gap_run && att == 1) gap_w <= gap_cnt;
                if (bits < 8 * cur_n) begin
                    if (cfg_data !== pat(bits >> 3)[bits % 8]) mism <= mism + 1;
                    if (hit) err <= 1'b1;
                    bits <= bits + 1;
                end else begin
                    trail <= trail + 1;
                end
            end else if (gap_run) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic pulse_start(input int cnt);
        byte_count = CW'(cnt);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        while (!(done || fail) && !timeout) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(cfg_ce_n == 1'b1,    "R1 ce_n after reset", cfg_ce_n, 1);
        check(cfg_nconfig == 1'b1, "R1 nconfig after reset", cfg_nconfig, 1);
        check(!cfg_dclk && !cfg_data, "R1 dclk/data after reset", {cfg_dclk, cfg_data}, 0);
        check(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
        check(!in_ready && !rewind, "R1 ready/rewind after reset", {in_ready, rewind}, 0);

        // R10: oversized image is refused before any pin moves
        cur_n = 0;
        pulse_start(MAXB + 1);
        repeat (2) @(negedge clk);
        check(fail == 1'b1,     "R10 oversize fail", fail, 1);
        check(att == 0,         "R10 oversize no reset pulse", att, 0);
        check(cfg_ce_n == 1'b1, "R10 oversize ce_n untouched", cfg_ce_n, 1);
        check(busy == 1'b0,     "R10 oversize not busy", busy, 0);

        for (int v = 0; v < NV; v++) begin
            cur_n   = int'(VECS[v].n);
            err_att = int'(VECS[v].err_att);
            err_bit = int'(VECS[v].err_bit);
            cd_bad  = int'(VECS[v].cd_bad);
            stuck   = VECS[v].stuck;
            pulse_start(cur_n);
            check(busy && !done && !fail, "R11 busy after start", {busy, done, fail}, 4);
            wait_end();
            check(!timeout, "R9 run completes", timeout, 0);
            check(done == VECS[v].exp_done,  "R8 done outcome", done, VECS[v].exp_done);
            check(fail == !VECS[v].exp_done, "R9 fail outcome", fail, !VECS[v].exp_done);
            check(att == int'(VECS[v].exp_att), "R9 attempt count", att, VECS[v].exp_att);
            check(rew == int'(VECS[v].exp_rew), "R6 rewind count", rew, VECS[v].exp_rew);
            check(cfg_ce_n == 1'b0, "R1 ce_n held low", cfg_ce_n, 0);
            check(busy == 1'b0, "R11 idle at end", busy, 0);
            if (VECS[v].stuck) begin
                check(bits == 0 && trail == 0, "R3 no clocks after stuck status", bits + trail, 0);
            end
            if (VECS[v].exp_done) begin
                check(mism == 0, "R5 bit order and content", mism, 0);
                check(bits == 8 * cur_n, "R5 data bit count", bits, 8 * cur_n);
                check(trail == TRAIL, "R7 trailing clock count", trail, TRAIL);
                check(cfg_data == 1'b0, "R7 data low after trail", cfg_data, 0);
            end
            if (v == 0) begin
                check(pre_w >= 100, "R2 settle before reset pulse", pre_w, 100);
                check(low_w == 10,  "R2 reset low width", low_w, 10);
                check(gap_w >= 100, "R4 wait after release", gap_w, 100);
            end
        end

        if (timeout) check(1'b0, "R9 watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule